// File: doc/BRIEF.md
# Calendar Time-of-Year Counter with Alarms

This block is a calendar that holds seconds, minutes, hours, day of month, month and year. It advances from an external sub-second step pulse. Sixteen steps make one second, and a 4-bit sub-second counter records how many steps have arrived in the current second. Software reaches it over a simple 32-bit register bus with single-cycle writes and a combinational read port. Through that bus it sets the time, reads it back, programs three alarm words and controls counting through one control register.

Counting runs only when two control bits are both set: a calendar enable and an oscillator enable. While counting is stopped, the time holds still and reads return the frozen value. Writes to the time, year and alarm registers are dropped during that period. When both bits are set again, counting resumes from the held value.

An alarm matches on year (low 6 bits only), month, day, hour, minute and second. When the calendar crosses a second boundary into a time that any alarm matches, the block raises a single-cycle interrupt pulse.

Top module: `toy_calendar`

## Requirements
- R1: After reset the time word reads 0x0420_0000 (month 1, day 1, all other fields zero). The year reads RESET_YEAR (default 2000). The control register and all three alarm registers read zero.
- R2: Counting is enabled only when control bit 11 and control bit 8 are both 1. With either bit clear, step pulses leave the time unchanged. The control register at offset 0x40 reads back all 32 bits as written.
- R3: While enabled, each step pulse adds one to the sub-second field (time word bits 3:0). The 16th step clears that field and adds one second.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day.
- R5: The day wraps to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. February has 29 days when the year is divisible by 4 and is either not divisible by 100 or divisible by 400; otherwise it has 28. All other months have 31. Month (1-based) wraps from 12 to 1 and adds one to the year.
- R6: The time word is written at offset 0x24 and read at offset 0x2C. Its layout is month 31:26, day 25:21, hour 20:16, minute 15:10, second 9:4 and sub-second 3:0. A write loads those fields and clears the sub-second field. The year is written at offset 0x28 and read at offset 0x30, zero-extended in the low YEAR_W bits.
- R7: While disabled, writes to 0x24, 0x28 and the alarm offsets are ignored, and reads return the value held when counting stopped. After re-enabling, counting continues from that held value, including the sub-second field.
- R8: The three alarm registers are at 0x34, 0x38 and 0x3C and read back as written. Their layout is year low 6 bits 31:26, month 25:22, day 21:17, hour 16:12, minute 11:6 and second 5:0.
- R9: The interrupt is high for exactly one cycle, in the cycle after the step that completes a second, when the new time matches any alarm. Matching compares the alarm year field against the low 6 bits of the year. A match that exists without a second boundary does not fire.
- R10: An access whose address bits 1:0 are not zero is ignored and reads zero. Unmapped offsets and the write-only offsets 0x24 and 0x28 read zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sub-second step pulse, 16 per second |
| req_valid | input | 1 | Bus access valid |
| req_write | input | 1 | Bus access is a write |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for req_addr |
| irq_o | output | 1 | One-cycle alarm pulse |

## Verification
The conditions that are hardest to reach from the ports are the carry chains that end in a day, month or year change. These include the February length under the 4-, 100- and 400-year rules, and an alarm that coincides with such a carry. The stimulus reaches them by writing a time one second before the boundary and then issuing sixteen steps. Random trials write dates with minutes and hours near their limits and place alarms a few seconds ahead. A bench model advances with every step and predicts each interrupt pulse.

// File: rtl/toy_calendar.sv
module toy_calendar #(
  parameter int          YEAR_W     = 16,
  parameter int unsigned RESET_YEAR = 2000,
  parameter int          ADDR_W     = 8,
  parameter int          NUM_ALARMS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFF_TIME_WR = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] OFF_YEAR_WR = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFF_TIME_RD = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFF_YEAR_RD = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_CTRL    = ADDR_W'(8'h40);
  localparam int                OFF_ALARM0  = 'h34;
  localparam int                CAL_BIT     = 11;
  localparam int                OSC_BIT     = 8;

  logic [3:0]        sub_q;
  logic [5:0]        sec_q, min_q, mon_q;
  logic [4:0]        hour_q, day_q;
  logic [YEAR_W-1:0] year_q;
  logic [31:0]       ctrl_q;
  logic [31:0]       alarm_q [NUM_ALARMS];
  logic              step_q;
  logic [4:0]        mdays;
  logic [NUM_ALARMS-1:0] hit;

  wire en      = ctrl_q[CAL_BIT] & ctrl_q[OSC_BIT];
  wire aligned = (req_addr[1:0] == 2'b00);
  wire wr      = req_valid & req_write & aligned;
  wire wr_cfg  = wr & en;
  wire wr_time = wr_cfg & (req_addr == OFF_TIME_WR);
  wire wr_year = wr_cfg & (req_addr == OFF_YEAR_WR);
  wire wr_ctrl = wr & (req_addr == OFF_CTRL);

  wire leap = (year_q[1:0] == 2'b00) &&
              (((year_q % YEAR_W'(100)) != '0) || ((year_q % YEAR_W'(400)) == '0));

  always_comb begin
    case (mon_q)
      6'd4, 6'd6, 6'd9, 6'd11: mdays = 5'd30;
      6'd2:                    mdays = leap ? 5'd29 : 5'd28;
      default:                 mdays = 5'd31;
    endcase
  end

  wire advance  = en & tick_i;
  wire sec_end  = advance  & (sub_q == 4'hF);
  wire min_end  = sec_end  & (sec_q >= 6'd59);
  wire hour_end = min_end  & (min_q >= 6'd59);
  wire day_end  = hour_end & (hour_q >= 5'd23);
  wire mon_end  = day_end  & (day_q >= mdays);
  wire year_end = mon_end  & (mon_q >= 6'd12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= '0;
      sec_q  <= '0;
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= 5'd1;
      mon_q  <= 6'd1;
      year_q <= YEAR_W'(RESET_YEAR);
      ctrl_q <= '0;
      step_q <= 1'b0;
      for (int i = 0; i < NUM_ALARMS; i++) alarm_q[i] <= '0;
    end else begin
      step_q <= sec_end & ~wr_time;
      if (wr_time) begin
        sub_q  <= '0;
        sec_q  <= req_wdata[9:4];
        min_q  <= req_wdata[15:10];
        hour_q <= req_wdata[20:16];
        day_q  <= req_wdata[25:21];
        mon_q  <= req_wdata[31:26];
      end else if (advance) begin
        sub_q <= sub_q + 4'd1;
        if (sec_end)  sec_q  <= min_end  ? 6'd0 : sec_q + 6'd1;
        if (min_end)  min_q  <= hour_end ? 6'd0 : min_q + 6'd1;
        if (hour_end) hour_q <= day_end  ? 5'd0 : hour_q + 5'd1;
        if (day_end)  day_q  <= mon_end  ? 5'd1 : day_q + 5'd1;
        if (mon_end)  mon_q  <= year_end ? 6'd1 : mon_q + 6'd1;
      end
      if (wr_year) year_q <= req_wdata[YEAR_W-1:0];
      else if (year_end && !wr_time) year_q <= year_q + YEAR_W'(1);
      if (wr_ctrl) ctrl_q <= req_wdata;
      for (int i = 0; i < NUM_ALARMS; i++)
        if (wr_cfg && req_addr == ADDR_W'(OFF_ALARM0 + 4*i)) alarm_q[i] <= req_wdata;
    end
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    assign hit[i] = (alarm_q[i][31:26] == year_q[5:0]) &&
                    ({2'b00, alarm_q[i][25:22]} == mon_q) &&
                    (alarm_q[i][21:17] == day_q) &&
                    (alarm_q[i][16:12] == hour_q) &&
                    (alarm_q[i][11:6] == min_q) &&
                    (alarm_q[i][5:0] == sec_q);
    AST_ALARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !en |=> $stable(alarm_q[i])); // R7
  end

  assign irq_o = step_q & en & (|hit);

  always_comb begin
    rd_data = '0;
    if (aligned) begin
      if (req_addr == OFF_TIME_RD) rd_data = {mon_q, day_q, hour_q, min_q, sec_q, sub_q};
      if (req_addr == OFF_YEAR_RD) rd_data = 32'(year_q);
      if (req_addr == OFF_CTRL)    rd_data = ctrl_q;
      for (int i = 0; i < NUM_ALARMS; i++)
        if (req_addr == ADDR_W'(OFF_ALARM0 + 4*i)) rd_data = alarm_q[i];
    end
  end

  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> ($stable(sub_q) && $stable(sec_q) && $stable(min_q) && $stable(hour_q) && $stable(day_q) && $stable(mon_q) && $stable(year_q))); // R7
  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n) (advance && !wr_time) |=> sub_q == $past(sub_q) + 4'd1); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (advance && !wr_time && sub_q == 4'hF && sec_q == 6'd59) |=> sec_q == 6'd0); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_o |=> !irq_o); // R9
  AST_IRQ_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> sub_q == 4'd0); // R9
endmodule

// File: tb/toy_calendar_tb.sv
module toy_calendar_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_sub, m_sec, m_min, m_hour, m_day, m_mon, m_year;
  logic [31:0] m_alarm [3];

  toy_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_leap(int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int days_in(int m, int y);
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    if (m == 2) return is_leap(y) ? 29 : 28;
    return 31;
  endfunction

  function automatic logic [31:0] pack_time(int mo, int d, int h, int mi, int s, int sb);
    return {6'(mo), 5'(d), 5'(h), 6'(mi), 6'(s), 4'(sb)};
  endfunction

  function automatic logic [31:0] pack_alarm(int y, int mo, int d, int h, int mi, int s);
    return {6'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  function automatic logic [31:0] model_word();
    return pack_time(m_mon, m_day, m_hour, m_min, m_sec, m_sub);
  endfunction

  task automatic model_step(output bit fire);
    fire = 0;
    m_sub++;
    if (m_sub == 16) begin
      m_sub = 0; m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hour++;
          if (m_hour == 24) begin
            m_hour = 0; m_day++;
            if (m_day > days_in(m_mon, m_year)) begin
              m_day = 1; m_mon++;
              if (m_mon == 13) begin m_mon = 1; m_year++; end
            end
          end
        end
      end
      for (int i = 0; i < 3; i++)
        if (m_alarm[i] == pack_alarm(m_year, m_mon, m_day, m_hour, m_min, m_sec)) fire = 1;
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_addr = a;
    #1 d = rd_data;
  endtask

  task automatic raw_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
  endtask

  task automatic model_tick(string req);
    bit fire;
    raw_tick();
    model_step(fire);
    chk(req, 32'(irq_o), 32'(fire));
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) model_tick(req);
  endtask

  task automatic set_time(int y, int mo, int d, int h, int mi, int s);
    bus_wr(8'h28, 32'(y));
    bus_wr(8'h24, pack_time(mo, d, h, mi, s, 9));
    m_year = y; m_mon = mo; m_day = d; m_hour = h; m_min = mi; m_sec = s; m_sub = 0;
  endtask

  task automatic set_alarm(int i, logic [31:0] v);
    bus_wr(8'(8'h34 + 4*i), v);
    m_alarm[i] = v;
  endtask

  task automatic check_time(string req);
    logic [31:0] v;
    bus_rd(8'h2C, v); chk(req, v, model_word());
    bus_rd(8'h30, v); chk(req, v, 32'(m_year));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int pulses;
    void'($urandom(32'd20240229));
    m_sub = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 1; m_mon = 1; m_year = 2000;
    for (int i = 0; i < 3; i++) m_alarm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(8'h2C, v); chk("R1", v, 32'h0420_0000);
    bus_rd(8'h30, v); chk("R1", v, 32'd2000);
    bus_rd(8'h40, v); chk("R1", v, 32'h0);
    for (int i = 0; i < 3; i++) begin bus_rd(8'(8'h34 + 4*i), v); chk("R1", v, 32'h0); end

    // R2 one enable bit alone does not count
    bus_wr(8'h40, 32'h0000_0800);
    repeat (20) raw_tick();
    bus_rd(8'h2C, v); chk("R2", v, 32'h0420_0000);
    bus_wr(8'h40, 32'h0000_0100);
    repeat (20) raw_tick();
    bus_rd(8'h2C, v); chk("R2", v, 32'h0420_0000);
    bus_wr(8'h24, pack_time(7, 7, 7, 7, 7, 0));
    bus_rd(8'h2C, v); chk("R7", v, 32'h0420_0000);
    bus_wr(8'h40, 32'hA5A5_0900);
    bus_rd(8'h40, v); chk("R2", v, 32'hA5A5_0900);

    // R3 sub-second steps
    ticks(5, "R3");
    bus_rd(8'h2C, v); chk("R3", v, 32'h0420_0005);
    ticks(11, "R3");
    bus_rd(8'h2C, v); chk("R3", v, 32'h0420_0010);

    // R6 time and year write/read
    set_time(2024, 3, 15, 10, 20, 30);
    check_time("R6");

    // R4 carries
    set_time(2024, 6, 10, 10, 59, 59); ticks(16, "R4"); check_time("R4");
    set_time(2024, 6, 10, 12, 34, 59); ticks(16, "R4"); check_time("R4");
    set_time(2024, 6, 10, 22, 59, 59); ticks(16, "R4"); check_time("R4");

    // R5 month lengths and leap rules
    set_time(2024, 2, 28, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2023, 2, 28, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2100, 2, 28, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2000, 2, 28, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2000, 2, 29, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2025, 4, 30, 23, 59, 59); ticks(16, "R5"); check_time("R5");
    set_time(2025, 12, 31, 23, 59, 59); ticks(16, "R5"); check_time("R5");

    // R7 freeze, ignored writes, resume
    set_time(2030, 8, 20, 5, 6, 7);
    ticks(7, "R7");
    set_alarm(1, pack_alarm(2030, 8, 20, 5, 6, 40));
    bus_wr(8'h40, 32'h0000_0100);
    repeat (40) raw_tick();
    bus_wr(8'h24, pack_time(1, 2, 3, 4, 5, 0));
    bus_wr(8'h28, 32'd1999);
    bus_wr(8'h34, 32'h1234_5678);
    check_time("R7");
    bus_rd(8'h34, v); chk("R7", v, m_alarm[0]);
    bus_wr(8'h40, 32'h0000_0900);
    ticks(16, "R7");
    check_time("R7");

    // R8 alarm readback, R9 pulse
    set_time(2024, 5, 10, 8, 0, 0);
    set_alarm(0, pack_alarm(2024, 5, 10, 8, 0, 3));
    set_alarm(1, pack_alarm(2025, 5, 10, 8, 0, 3));
    set_alarm(2, pack_alarm(2024, 5, 10, 8, 0, 3));
    for (int i = 0; i < 3; i++) begin bus_rd(8'(8'h34 + 4*i), v); chk("R8", v, m_alarm[i]); end
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      model_tick("R9");
      if (irq_o) pulses++;
    end
    chk("R9", 32'(pulses), 32'd1);
    set_time(2024, 5, 10, 8, 0, 3);
    ticks(3, "R9");
    set_time(2024, 12, 31, 23, 59, 59);
    set_alarm(0, pack_alarm(2025, 1, 1, 0, 0, 0));
    ticks(16, "R9");

    // Random trials
    for (int it = 0; it < 40; it++) begin
      int y, mo, d, h, mi, s, n;
      y  = $urandom_range(2090, 1990);
      mo = $urandom_range(12, 1);
      d  = $urandom_range(days_in(mo, y), days_in(mo, y) - 2);
      h  = ($urandom_range(1, 0) == 1) ? 23 : $urandom_range(23, 0);
      mi = $urandom_range(59, 57);
      s  = $urandom_range(59, 50);
      set_time(y, mo, d, h, mi, s);
      for (int k = 0; k < 3; k++)
        set_alarm(k, pack_alarm(y, mo, d, h, mi, (s + $urandom_range(6, 1)) % 60));
      n = $urandom_range(160, 16);
      ticks(n, "R4");
      check_time("R5");
    end

    // R10 alignment and unmapped offsets
    bus_rd(8'h2D, v); chk("R10", v, 32'h0);
    bus_rd(8'h24, v); chk("R10", v, 32'h0);
    bus_rd(8'h50, v); chk("R10", v, 32'h0);
    bus_wr(8'h26, pack_time(1, 1, 1, 1, 1, 0));
    bus_wr(8'h41, 32'h0);
    bus_wr(8'h50, 32'hFFFF_FFFF);
    check_time("R10");
    bus_rd(8'h40, v); chk("R10", v, 32'h0000_0900);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule